// File: doc/BRIEF.md
# Serial Memory Read Sequencer

This block is the read path of a three-wire serial memory slave that holds 256 words of 16 bits. When the instruction decoder has recognised a read and captured its 8-bit address, it pulses a start strobe. The sequencer then fetches the addressed word from a synchronous memory. It drives one dummy zero on the data-out pin, followed by the word, most significant bit first. All sequencer flops run on the rising edge of the serial clock, so data-out changes only on that edge.

While chip select stays high, the sequencer keeps reading. It increments the address, wraps from 255 to 0, and streams the next word directly after the last bit of the current one, with no dummy bit in between. The next word is requested from memory while bit 1 of the current word is on the pin, so the stream has no gap. Dropping chip select ends the read at once: the output-enable flag, which stands in for a tri-stated pin, falls in the same cycle. Reads do not depend on any write-protection state, and the block has no input for one.

Top module: `serial_rd_seq`

## Requirements
- R1: During reset and after it, with no read started, `dout_oe_o` and `mem_re_o` are 0.
- R2: A read starts when `rd_start_i` and `cs_i` are both 1 at a rising edge. For the whole next cycle, `dout_oe_o` is 1 and `dout_o` is the dummy bit 0.
- R3: On each of the next 16 rising edges, `dout_o` shows the next bit of the word at the start address, starting with bit 15 and ending with bit 0.
- R4: If `cs_i` stays 1 after bit 0, the edge that ends bit 0 shows bit 15 of the word at the next address. No dummy bit is inserted, and this repeats for every following word.
- R5: The sequential address is 8 bits wide and wraps from 255 to 0.
- R6: `dout_oe_o` is 0 in any cycle where `cs_i` is 0, with no edge needed. The read is abandoned at the next edge, so raising `cs_i` again without a new start leaves `dout_oe_o` at 0.
- R7: A start strobe seen while `cs_i` is 0 is ignored, and no read begins.
- R8: The memory has a read latency of one edge: `mem_rdata_i` holds the word at the address sampled at the edge where `mem_re_o` was 1. `mem_re_o` is 1 with `mem_addr_o` = `rd_addr_i` in the start cycle. It is also 1 with `mem_addr_o` = current address + 1 in the cycle that shows bit 1 of a word. In every other cycle it is 0.
- R9: A start strobe during an ongoing read restarts the sequence, with the dummy bit, at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; all state changes on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| rd_start_i | input | 1 | Decoded read strobe, one cycle |
| rd_addr_i | input | 8 | Start address captured with the strobe |
| mem_re_o | output | 1 | Memory read request |
| mem_addr_o | output | 8 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, one edge after the request |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Data-out drive enable (0 means high impedance) |

## Verification
The dummy bit is due one edge after the start strobe. Bit 15 is due two edges after it, and each following bit one edge later. The first bit of the next word appears one edge after bit 0, and the memory request precedes it by two edges. The output-enable response to chip select is combinational, so it is due within the same cycle. The bench drives its inputs a quarter period after each rising edge and samples every output at the falling edge. It advances a behavioural model (word address, bit index, dummy flag) at each rising edge, so each comparison lands in the cycle where the value is due.

// File: rtl/serial_rd_pkg.sv
package serial_rd_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned CNT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DUMMY  = 2'd1,
    ST_STREAM = 2'd2
  } rd_state_e;
endpackage

// File: rtl/serial_rd_ctrl.sv
module serial_rd_ctrl
  import serial_rd_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic start_i,
  output logic begin_o,
  output logic load_o,
  output logic fetch_o,
  output logic shift_o,
  output logic active_o
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_IDX = CW'(DW - 1);

  rd_state_e      state_q;
  logic [CW-1:0]  idx_q;

  assign begin_o  = cs_i & start_i;
  assign load_o   = cs_i & ~start_i &
                    ((state_q == ST_DUMMY) | ((state_q == ST_STREAM) & (idx_q == '0)));
  assign fetch_o  = cs_i & ~start_i & (state_q == ST_STREAM) & (idx_q == CW'(1));
  assign shift_o  = cs_i & ~start_i & (state_q == ST_STREAM) & (idx_q != '0);
  assign active_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (!cs_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_DUMMY;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_DUMMY: begin
          state_q <= ST_STREAM;
          idx_q   <= LAST_IDX;
        end
        ST_STREAM: idx_q <= (idx_q == '0) ? LAST_IDX : idx_q - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/serial_rd_addr.sv
module serial_rd_addr
  import serial_rd_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          begin_i,
  input  logic          fetch_i,
  input  logic [AW-1:0] start_addr_i,
  output logic [AW-1:0] req_addr_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_inc;

  assign addr_inc   = addr_q + 1'b1;  // natural wrap
  assign req_addr_o = begin_i ? start_addr_i : addr_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (begin_i) addr_q <= start_addr_i;
    else if (fetch_i) addr_q <= addr_inc;
  end
endmodule

// File: rtl/serial_rd_shift.sv
module serial_rd_shift
  import serial_rd_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [DW-1:0] data_i,
  output logic          msb_o
);
  logic [DW-1:0] sr_q;

  assign msb_o = sr_q[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (clear_i) sr_q <= '0;  // dummy zero
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[DW-2:0], 1'b0};
  end
endmodule

// File: rtl/serial_rd_seq.sv
module serial_rd_seq
  import serial_rd_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_start_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          dout_o,
  output logic          dout_oe_o
);
  logic begin_s, load_s, fetch_s, shift_s, active_s, msb_s;

  serial_rd_ctrl #(.DW(DW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .start_i  (rd_start_i),
    .begin_o  (begin_s),
    .load_o   (load_s),
    .fetch_o  (fetch_s),
    .shift_o  (shift_s),
    .active_o (active_s)
  );

  serial_rd_addr #(.AW(AW)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .begin_i      (begin_s),
    .fetch_i      (fetch_s),
    .start_addr_i (rd_addr_i),
    .req_addr_o   (mem_addr_o)
  );

  serial_rd_shift #(.DW(DW)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (begin_s),
    .load_i  (load_s),
    .shift_i (shift_s),
    .data_i  (mem_rdata_i),
    .msb_o   (msb_s)
  );

  assign mem_re_o  = begin_s | fetch_s;
  assign dout_oe_o = cs_i & active_s;
  assign dout_o    = msb_s;
endmodule

// File: rtl/serial_rd_seq_chk.sv
module serial_rd_seq_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic          rd_start_i,
  input logic [AW-1:0] rd_addr_i,
  input logic          mem_re_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_rdata_i,
  input logic          dout_o,
  input logic          dout_oe_o
);
  p_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && !rd_start_i) |=> !dout_oe_o);

  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && rd_start_i) |=> !dout_oe_o);

  p_dummy_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_start_i) |=> (dout_o == 1'b0));

  p_msb_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_i && rd_start_i) && cs_i && !rd_start_i)
      |=> (dout_oe_o || !cs_i) && (dout_o == $past(mem_rdata_i[DW-1])));

  p_start_fetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_start_i) |-> (mem_re_o && mem_addr_o == rd_addr_i));
endmodule

bind serial_rd_seq serial_rd_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_i        (cs_i),
  .rd_start_i  (rd_start_i),
  .rd_addr_i   (rd_addr_i),
  .mem_re_o    (mem_re_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rdata_i (mem_rdata_i),
  .dout_o      (dout_o),
  .dout_oe_o   (dout_oe_o)
);

// File: tb/tb_serial_rd_seq.sv
module tb_serial_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          mem_re;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          dout, dout_oe;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  logic [DW-1:0] mem [256];

  // behavioural reference state
  bit m_act = 0;
  int m_phase = 0;   // -1 dummy, else bit index shown
  int m_addr = 0;
  int m_words = 0;   // words completed since start
  bit m_wrapped = 0;

  serial_rd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_start_i(start),
    .rd_addr_i(addr), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .dout_o(dout), .dout_oe_o(dout_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503 + 12345) ^ (i << 9));

  always @(posedge clk) if (mem_re) mem_rdata <= mem[mem_addr];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_phase = 0; m_addr = 0; m_words = 0; m_wrapped = 0;
    end else if (!cs) begin
      m_act = 0;
    end else if (start) begin
      m_act = 1; m_phase = -1; m_addr = int'(addr); m_words = 0; m_wrapped = 0;
    end else if (m_act) begin
      if (m_phase == -1) m_phase = DW - 1;
      else if (m_phase > 0) m_phase = m_phase - 1;
      else begin
        if (m_addr == 255) m_wrapped = 1;
        m_addr = (m_addr + 1) % 256;
        m_words++;
        m_phase = DW - 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      finish_run();
    end
  end

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    bit exp_oe, exp_re, exp_d;
    int exp_a;
    string tag;
    if (!rst_n) begin
      chk(dout_oe == 1'b0, "R1 oe in reset", dout_oe, 0);
      chk(mem_re == 1'b0, "R1 re in reset", mem_re, 0);
    end else begin
      exp_oe = cs && m_act;
      tag = !cs ? "R6 oe follows cs" : (m_act ? "R2 oe during read" : "R1/R7 oe idle");
      chk(dout_oe == exp_oe, tag, dout_oe, exp_oe);
      if (exp_oe) begin
        exp_d = (m_phase < 0) ? 1'b0 : mem[m_addr][m_phase];
        if (m_phase < 0)     tag = "R2 dummy bit";
        else if (m_wrapped)  tag = "R5 wrapped word bit";
        else if (m_words > 0) tag = "R4 streamed word bit";
        else                 tag = "R3 first word bit";
        chk(dout == exp_d, tag, dout, exp_d);
      end
      exp_re = cs && (start || (m_act && m_phase == 1));
      chk(mem_re == exp_re, "R8 read request", mem_re, exp_re);
      if (exp_re) begin
        exp_a = start ? int'(addr) : (m_addr + 1) % 256;
        chk(int'(mem_addr) == exp_a, "R8 read address", mem_addr, exp_a);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
    end
  endtask

  task automatic begin_read(input logic [AW-1:0] a);
    cs = 1; start = 1; addr = a;
    step(1);
    start = 0; addr = 8'h00;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(3);                       // R1 idle after reset
    // R2 R3 R4: two full words then abort (R6)
    begin_read(8'h10);
    step(1 + 2*DW + 3);
    cs = 0;
    #1 chk(dout_oe == 1'b0, "R6 immediate oe drop", dout_oe, 0);
    step(2);
    cs = 1;                        // R6 no resume without start
    step(4);
    chk(dout_oe == 1'b0, "R6 no resume", dout_oe, 0);
    cs = 0; step(1);
    // R7 start with cs low ignored
    start = 1; addr = 8'h33; step(1);
    start = 0; cs = 1; step(5);
    chk(dout_oe == 1'b0, "R7 ignored start", dout_oe, 0);
    cs = 0; step(1);
    // R5 wrap across 255 -> 0
    begin_read(8'hFE);
    step(3*DW + 2);
    cs = 0; step(2);
    // R9 restart mid-word
    begin_read(8'h80);
    step(7);
    begin_read(8'h40);
    step(1 + DW + 4);
    // abort mid-word, then fresh read
    cs = 0; step(1);
    begin_read(8'hFF);
    step(2*DW + 1);
    cs = 0; step(3);
    finish_run();
  end
endmodule